// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block is a host-side controller that writes a 7-bit attenuation setting into a serially programmed step attenuator. A request arrives with a 7-bit value on a valid/ready handshake. Once it is accepted, the block shifts out an 8-bit word, least significant bit first. Bits 0 to 6 carry the request and bit 7 is always zero. After the last shift it raises a latch-enable pulse that moves the word into the attenuator core.

Every timing interval is derived from a nanosecond limit and the system clock period, and is rounded up to whole system clock cycles. The limits are the shift clock high, low and period times, the latch setup and pulse width, and the mode-select lead time. Serial data changes only while the shift clock is low, so it is stable on both sides of each rising edge. The mode-select output is tied to the serial setting. After reset, requests are refused until that setting has been held for the required lead time.

With the defaults (5 ns system clock) the derived counts are: 6 cycles shift clock high (HI), 14 cycles low (LO, stretched to meet the 100 ns period), 2 cycles from the last falling edge to latch enable (SU), 6 cycles latch pulse (PW), and 20 cycles of mode-select lead after reset (MSU).

Top module: `sat_prog`

## Requirements
- R1: An accepted request sends the word {1'b0, req_atten} least significant bit first. Bit b is on ser_data from the falling edge that opens slot b until the falling edge that closes it. Slot 0 opens at the acceptance edge.
- R2: ser_data never changes while ser_clk is high, so every rising edge has at least LO cycles of setup and HI cycles of hold.
- R3: Each shift clock pulse is high for exactly HI cycles and preceded by LO low cycles (defaults 6 and 14). HI+LO meets the 100 ns minimum period.
- R4: latch_en stays low during the whole shift phase. It rises SU cycles after the last falling edge of ser_clk, and ser_clk is low whenever latch_en is high.
- R5: latch_en stays high for exactly PW cycles.
- R6: req_ready is low from the acceptance edge until latch_en falls. done pulses high for exactly one cycle, in the cycle in which latch_en returns low, and req_ready is high again in that same cycle.
- R7: Between transfers ser_clk and latch_en idle low and done is low.
- R8: mode_serial is held at 1 (serial). req_ready stays low for the first MSU clock cycles after reset is released and rises after exactly MSU cycles.
- R9: req_valid and req_atten are ignored while a transfer is in progress. The waveform of the running transfer does not change.
- R10: Each transfer produces exactly 8 rising edges on ser_clk. A request held valid when done pulses is accepted on the next edge with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Attenuation request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_atten | input | 7 | Requested attenuation code |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Shift clock, idles low |
| latch_en | output | 1 | Latch-enable pulse |
| mode_serial | output | 1 | Mode select, held at serial (1) |
| done | output | 1 | One-cycle pulse when latch enable falls |

## Verification
The assertions assume that rst_n is held low for at least one clock edge. They place no other demands on the inputs: they are written so that they hold for any pattern of req_valid and req_atten. This covers requests that are left asserted, or that change, during a transfer. The stimulus changes inputs only on falling clock edges. On purpose, it keeps req_valid high with new data during a busy transfer and also back-to-back across done, so that the rules for ignoring inputs and for accepting the next request are exercised.

// File: rtl/sat_prog.sv
module sat_prog #(
  parameter int WIDTH      = 7,
  parameter int SYS_NS     = 5,
  parameter int CLK_HI_NS  = 30,
  parameter int CLK_LO_NS  = 30,
  parameter int CLK_PER_NS = 100,
  parameter int LE_SU_NS   = 10,
  parameter int LE_PW_NS   = 30,
  parameter int MODE_SU_NS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] req_atten,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             latch_en,
  output logic             mode_serial,
  output logic             done
);
  localparam int NBITS   = WIDTH + 1;
  localparam int BW      = $clog2(NBITS);
  localparam int HI_CYC  = (CLK_HI_NS + SYS_NS - 1) / SYS_NS;
  localparam int LO_RAW  = (CLK_LO_NS + SYS_NS - 1) / SYS_NS;
  localparam int PER_CYC = (CLK_PER_NS + SYS_NS - 1) / SYS_NS;
  localparam int LO_CYC  = (LO_RAW > PER_CYC - HI_CYC) ? LO_RAW : PER_CYC - HI_CYC;
  localparam int SU_CYC  = (LE_SU_NS + SYS_NS - 1) / SYS_NS;
  localparam int PW_CYC  = (LE_PW_NS + SYS_NS - 1) / SYS_NS;
  localparam int MSU_CYC = (MODE_SU_NS + SYS_NS - 1) / SYS_NS;
  localparam int CW      = 16;
  localparam logic [BW-1:0] LAST = BW'(NBITS - 1);

  typedef enum logic [2:0] {IDLE, LOW, HIGH, SETUP, PULSE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    msu;
  logic [NBITS-1:0] sh;
  logic [BW-1:0]    bitn;

  assign mode_serial = 1'b1;
  assign ser_data    = sh[0];
  assign req_ready   = (st == IDLE) && (msu == CW'(MSU_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) msu <= '0;
    else if (msu != CW'(MSU_CYC)) msu <= msu + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      sh       <= '0;
      bitn     <= '0;
      ser_clk  <= 1'b0;
      latch_en <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid && req_ready) begin
          sh   <= {1'b0, req_atten};
          bitn <= '0;
          cnt  <= CW'(LO_CYC - 1);
          st   <= LOW;
        end
        LOW: if (cnt == '0) begin
          ser_clk <= 1'b1;
          cnt     <= CW'(HI_CYC - 1);
          st      <= HIGH;
        end else cnt <= cnt - 1'b1;
        HIGH: if (cnt == '0) begin
          ser_clk <= 1'b0;
          if (bitn == LAST) begin
            cnt <= CW'(SU_CYC - 1);
            st  <= SETUP;
          end else begin
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
            cnt  <= CW'(LO_CYC - 1);
            st   <= LOW;
          end
        end else cnt <= cnt - 1'b1;
        SETUP: if (cnt == '0) begin
          latch_en <= 1'b1;
          cnt      <= CW'(PW_CYC - 1);
          st       <= PULSE;
        end else cnt <= cnt - 1'b1;
        PULSE: if (cnt == '0) begin
          latch_en <= 1'b0;
          done     <= 1'b1;
          st       <= IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sat_prog_chk.sv
module sat_prog_chk #(
  parameter int MIN_HI = 6,
  parameter int MIN_LO = 14,
  parameter int MIN_PW = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ser_data,
  input logic ser_clk,
  input logic latch_en,
  input logic done
);
  logic [15:0] hi_run, lo_run, pw_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      pw_run <= '0;
    end else begin
      hi_run <= ser_clk  ? hi_run + 1'b1 : '0;
      lo_run <= !ser_clk ? lo_run + 1'b1 : '0;
      pw_run <= latch_en ? pw_run + 1'b1 : '0;
    end
  end

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  // R3
  clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_run >= 16'(MIN_HI)));
  // R3
  clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> (lo_run >= 16'(MIN_LO)));
  // R4
  le_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> !ser_clk);
  // R5
  le_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> (pw_run >= 16'(MIN_PW)));
  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> done);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en || ser_clk) |-> !req_ready);
endmodule

bind sat_prog sat_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ser_data(ser_data),
  .ser_clk(ser_clk), .latch_en(latch_en), .done(done)
);

// File: tb/sat_prog_tb.sv
module sat_prog_tb;
  localparam int T   = 5;
  localparam int H   = (30 + T - 1) / T;
  localparam int LR  = (30 + T - 1) / T;
  localparam int PR  = (100 + T - 1) / T;
  localparam int L   = (LR > PR - H) ? LR : PR - H;
  localparam int S   = (10 + T - 1) / T;
  localparam int P   = (30 + T - 1) / T;
  localparam int MSU = (100 + T - 1) / T;
  localparam int E   = 8 * (L + H) + S + P;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [6:0] req_atten = '0;
  logic req_ready, ser_data, ser_clk, latch_en, mode_serial, done;
  int checks = 0, failures = 0, rises = 0;
  bit finished = 0;

  always #(T / 2.0) clk = ~clk;

  sat_prog u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_atten(req_atten), .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en),
    .mode_serial(mode_serial), .done(done));

  always @(posedge ser_clk) rises++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle(int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7 ser_clk idle", ser_clk, 0);
      check("R7 latch_en idle", latch_en, 0);
      check("R7 done idle", done, 0);
      check("R6 ready idle", req_ready, 1);
    end
  endtask

  task automatic xfer(logic [6:0] d, bit noise, bit keep_next);
    logic [7:0] w = {1'b0, d};
    req_valid = 1;
    req_atten = d;
    check("R6 ready before accept", req_ready, 1);
    rises = 0;
    for (int k = 0; k <= E; k++) begin
      int b = k / (L + H);
      int r = k % (L + H);
      int eclk = 0, ele = 0, edat = 0;
      @(negedge clk);
      if (k == 0) begin
        req_valid = noise;
        req_atten = ~d;
      end
      if (noise && k == E - 1) req_valid = 0;
      if (noise && k > 0 && k < E - 1) req_atten = 7'(k * 13);
      if (k < 8 * (L + H)) begin
        eclk = (r >= L);
        edat = w[b];
      end else if (k >= 8 * (L + H) + S && k < E) ele = 1;
      check(noise ? "R9 R1 ser_data" : "R1 ser_data", ser_data, edat);
      check("R3 ser_clk", ser_clk, eclk);
      check("R4 R5 latch_en", latch_en, ele);
      check("R6 done", done, k == E);
      check("R6 ready", req_ready, k == E);
      check("R8 mode_serial", mode_serial, 1);
    end
    check("R10 rising edges", rises, 8);
    if (keep_next) req_valid = 1;
  endtask

  initial begin
    #(200000 * T);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset ser_clk", ser_clk, 0);
    check("R7 reset latch_en", latch_en, 0);
    check("R8 reset ready", req_ready, 0);
    req_valid = 1;
    req_atten = 7'h55;
    rst_n = 1;
    for (int n = 1; n <= MSU; n++) begin
      @(negedge clk);
      check("R8 mode lead ready", req_ready, n >= MSU);
      check("R7 no start during lead", ser_clk, 0);
    end
    req_valid = 0;
    idle(3);
    xfer(7'h01, 0, 0);
    idle(2);
    xfer(7'h7F, 0, 0);
    idle(1);
    xfer(7'h2A, 1, 0);
    idle(2);
    xfer(7'h00, 0, 1);
    xfer(7'h5A, 0, 1);
    xfer(7'h40, 0, 0);
    idle(4);
    finish_run();
  end
endmodule